// File: doc/BRIEF.md
# Flash Write-Completion Status Poller

After a program or erase has been launched in a parallel NOR flash, this block reads one flash location over and over until the part reports that its internal operation has finished. It then confirms that the data in the array is correct and reports the result on a one-cycle `donePulse` or `errPulse`. The block takes a start pulse together with the operation kind, the completion method, the expected word and the target address. It drives a simple request/valid read port towards the bus controller.

Completion can be detected in two ways. In polled-data mode the block watches one status bit: while a program is running that bit reads back inverted, and while an erase is running it reads zero. In toggle mode it watches another status bit, which alternates on every read while the part is busy. The flash finishes at a time the host cannot predict, so the block never accepts a status read alone. It waits a settle interval, reads the full word and compares it with the expected value. If that compare fails, it reads the location twice more and reports a failure only when those reads also disagree. A cycle budget bounds the time spent polling.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `donePulse`, `errPulse` and `rdReq` are all low.
- R2: A `startPulse` while idle latches its inputs. Every read of that operation then presents the latched `tgtAddr` on `rdAddr`, and `rdAddr` does not change while `rdReq` stays high.
- R3: In polled-data mode with `eraseMode`=0, a status read completes when data bit 7 equals bit 7 of `expData`.
- R4: In polled-data mode with `eraseMode`=1, a status read completes when data bit 7 is 1.
- R5: With `toggleMode`=1, a status read completes when its bit 6 equals bit 6 of the previous status read of the same operation. Bit 7 is not looked at in this mode.
- R6: After the completing status read, `rdReq` stays low for exactly `SETTLE_CYC` cycles before the final data read.
- R7: The final word is compared with `expData` for a program and with all ones for an erase. A match gives a `donePulse`.
- R8: A final-word mismatch triggers exactly two further reads. If both match, the result is `donePulse`.
- R9: If either of those two confirmation reads mismatches, the result is `errPulse`.
- R10: If no status read completes within `TMO_CYC` cycles of polling, `errPulse` is raised `TMO_CYC` cycles after the start is taken.
- R11: `donePulse` and `errPulse` are each one cycle wide, are never high together, and exactly one of them follows each accepted start.
- R12: A `startPulse` that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Begin polling; taken only while idle |
| eraseMode | input | 1 | 1 = erase is running, 0 = program is running |
| toggleMode | input | 1 | 1 = toggle-bit detection, 0 = polled-data detection |
| expData | input | DATA_W | Word that was programmed |
| tgtAddr | input | ADDR_W | Location to poll |
| rdReq | output | 1 | Read request, held until `rdValid` |
| rdAddr | output | ADDR_W | Read address |
| rdData | input | DATA_W | Read data, valid with `rdValid` |
| rdValid | input | 1 | One-cycle read completion strobe |
| donePulse | output | 1 | Operation finished with correct data |
| errPulse | output | 1 | Operation failed or timed out |

## Verification
The bench targets the race in which the status bit already shows completion but the full word still reads wrong. A design without the re-read would raise an error on a write that actually succeeded. A design that short-circuits after the first confirmation read would issue the wrong number of reads, and one that forgets an earlier bad confirmation would wrongly report done. Toggle mode is driven with words whose bit 7 already matches, so a poller that reads the wrong bit finishes too early and the read count changes. The settle gap is measured as idle request cycles, the timeout as an exact cycle count, and a start injected mid-poll must not disturb the address or add a second result pulse.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL, ST_SETTLE, ST_FINAL, ST_CONF1, ST_CONF2
  } pollState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // latch request, clear counters and history
    logic tmoTick;    // advance polling budget
    logic settleClr;  // restart settle counter
    logic settleTick; // advance settle counter
    logic notePrev;   // remember toggle bit of this read
    logic markBad;    // first confirmation read failed
  } dpCtl_t;
endpackage

// File: rtl/fpoll_dpath.sv
module fpoll_dpath
  import fpoll_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 22,
  parameter int TMO_CYC    = 4096,
  parameter int SETTLE_CYC = 50,
  parameter int POLL_BIT   = 7,
  parameter int TOG_BIT    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              eraseIn,
  input  logic              toggleIn,
  input  logic [DATA_W-1:0] expIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              statusDone,
  output logic              wordOk,
  output logic              tmoHit,
  output logic              settleDone,
  output logic              badSeen
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic [DATA_W-1:0] expReg;
  logic [ADDR_W-1:0] addrReg;
  logic              eraseReg, toggleReg, prevTog, havePrev, badReg;
  logic [TW-1:0]     tmoCnt;
  logic [SW-1:0]     settleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expReg    <= '0;
      addrReg   <= '0;
      eraseReg  <= 1'b0;
      toggleReg <= 1'b0;
      prevTog   <= 1'b0;
      havePrev  <= 1'b0;
      badReg    <= 1'b0;
      tmoCnt    <= '0;
      settleCnt <= '0;
    end else if (ctl.load) begin
      expReg    <= expIn;
      addrReg   <= addrIn;
      eraseReg  <= eraseIn;
      toggleReg <= toggleIn;
      havePrev  <= 1'b0;
      badReg    <= 1'b0;
      tmoCnt    <= '0;
    end else begin
      if (ctl.tmoTick && !tmoHit) tmoCnt <= tmoCnt + 1'b1;
      if (ctl.notePrev) begin
        prevTog  <= rdData[TOG_BIT];
        havePrev <= 1'b1;
      end
      if (ctl.settleClr) settleCnt <= '0;
      else if (ctl.settleTick && !settleDone) settleCnt <= settleCnt + 1'b1;
      if (ctl.markBad) badReg <= 1'b1;
    end
  end

  logic [DATA_W-1:0] target;
  logic              pollWant;
  always_comb begin
    target   = eraseReg ? '1 : expReg;
    pollWant = eraseReg ? 1'b1 : expReg[POLL_BIT];
    wordOk   = (rdData == target);
    if (toggleReg) statusDone = havePrev && (rdData[TOG_BIT] == prevTog);
    else           statusDone = (rdData[POLL_BIT] == pollWant);
  end

  assign tmoHit     = (tmoCnt == TW'(TMO_CYC - 1));
  assign settleDone = (settleCnt == SW'(SETTLE_CYC - 1));
  assign badSeen    = badReg;
  assign rdAddr     = addrReg;

  // R10: polling budget counter never runs past its limit
  p_tmo_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    tmoCnt <= TW'(TMO_CYC - 1));
  // R6: settle counter stays within its window
  p_settle_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    settleCnt <= SW'(SETTLE_CYC - 1));
endmodule

// File: rtl/fpoll_ctrl.sv
module fpoll_ctrl
  import fpoll_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startPulse,
  input  logic   rdValid,
  input  logic   statusDone,
  input  logic   wordOk,
  input  logic   tmoHit,
  input  logic   settleDone,
  input  logic   badSeen,
  output dpCtl_t ctl,
  output logic   rdReq,
  output logic   donePulse,
  output logic   errPulse
);
  pollState_t state, nxt;
  logic       setDone, setErr;

  always_comb begin
    nxt     = state;
    ctl     = '0;
    setDone = 1'b0;
    setErr  = 1'b0;
    case (state)
      ST_IDLE: if (startPulse) begin
        ctl.load = 1'b1;
        nxt      = ST_POLL;
      end
      ST_POLL: begin
        ctl.tmoTick = 1'b1;
        if (tmoHit) begin
          setErr = 1'b1;
          nxt    = ST_IDLE;
        end else if (rdValid) begin
          ctl.notePrev = 1'b1;
          if (statusDone) begin
            ctl.settleClr = 1'b1;
            nxt           = ST_SETTLE;
          end
        end
      end
      ST_SETTLE: begin
        ctl.settleTick = 1'b1;
        if (settleDone) nxt = ST_FINAL;
      end
      ST_FINAL: if (rdValid) begin
        if (wordOk) begin
          setDone = 1'b1;
          nxt     = ST_IDLE;
        end else nxt = ST_CONF1;
      end
      ST_CONF1: if (rdValid) begin
        if (!wordOk) ctl.markBad = 1'b1;
        nxt = ST_CONF2;
      end
      ST_CONF2: if (rdValid) begin
        if (wordOk && !badSeen) setDone = 1'b1;
        else                    setErr  = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      donePulse <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      state     <= nxt;
      donePulse <= setDone;
      errPulse  <= setErr;
    end
  end

  assign rdReq = (state == ST_POLL) || (state == ST_FINAL) ||
                 (state == ST_CONF1) || (state == ST_CONF2);

  // R11: result pulses are exclusive and one cycle wide
  p_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(donePulse && errPulse));
  p_done_once_r11: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  p_err_once_r11: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);
  // R6: the final read starts only once the settle window has run out
  p_settle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FINAL && $past(state) == ST_SETTLE) |-> $past(settleDone));
  // R7: a done result always follows a read that matched the target
  p_done_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> $past(rdValid && wordOk));
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fpoll_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 22,
  parameter int TMO_CYC    = 4096,
  parameter int SETTLE_CYC = 50,
  parameter int POLL_BIT   = 7,
  parameter int TOG_BIT    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              eraseMode,
  input  logic              toggleMode,
  input  logic [DATA_W-1:0] expData,
  input  logic [ADDR_W-1:0] tgtAddr,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdValid,
  output logic              donePulse,
  output logic              errPulse
);
  dpCtl_t ctl;
  logic   statusDone, wordOk, tmoHit, settleDone, badSeen;

  fpoll_ctrl u_ctrl (
    .clk, .rstN, .startPulse, .rdValid, .statusDone, .wordOk, .tmoHit,
    .settleDone, .badSeen, .ctl, .rdReq, .donePulse, .errPulse
  );

  fpoll_dpath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TMO_CYC(TMO_CYC),
    .SETTLE_CYC(SETTLE_CYC), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)
  ) u_dpath (
    .clk, .rstN, .ctl, .eraseIn(eraseMode), .toggleIn(toggleMode),
    .expIn(expData), .addrIn(tgtAddr), .rdData, .rdAddr, .statusDone,
    .wordOk, .tmoHit, .settleDone, .badSeen
  );

  // R2: the address is held for the whole of a pending read
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && $past(rdReq)) |-> $stable(rdAddr));
endmodule

// File: tb/flash_done_poller_test.sv
module flash_done_poller_test;
  localparam int DW = 16, AW = 22, TMO = 300, SETTLE = 50;

  logic          clk = 1'b0, rstN = 1'b0;
  logic          startPulse = 1'b0, eraseMode = 1'b0, toggleMode = 1'b0;
  logic [DW-1:0] expData = '0, rdData;
  logic [AW-1:0] tgtAddr = '0, rdAddr;
  logic          rdReq, rdValid, donePulse, errPulse;

  always #10 clk = ~clk;

  flash_done_poller #(.DATA_W(DW), .ADDR_W(AW), .TMO_CYC(TMO), .SETTLE_CYC(SETTLE)) uut (
    .clk, .rstN, .startPulse, .eraseMode, .toggleMode, .expData, .tgtAddr,
    .rdReq, .rdAddr, .rdData, .rdValid, .donePulse, .errPulse
  );

  // flash model: answers each request one cycle later from a script
  logic [DW-1:0] rsp [0:7];
  logic [DW-1:0] tail = '0;
  int            nRsp = 0, rdIdx = 0, baseIdx = 0;

  function automatic logic [DW-1:0] pickWord(input int k);
    if (k < nRsp) return rsp[k];
    return tail;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else if (rdReq && !rdValid) begin
      rdValid <= 1'b1;
      rdData  <= pickWord(rdIdx - baseIdx);
      rdIdx   <= rdIdx + 1;
    end else rdValid <= 1'b0;
  end

  // monitor with free-running totals
  logic          watching = 1'b0;
  logic [AW-1:0] expAddr = '0;
  int readTot = 0, lowTot = 0, addrBadTot = 0, doneTot = 0, errTot = 0;
  always @(negedge clk) begin
    if (watching) begin
      if (rdValid) readTot++;
      if (!rdReq && !donePulse && !errPulse) lowTot++;
      if (rdReq && rdAddr != expAddr) addrBadTot++;
    end
    if (donePulse) doneTot++;
    if (errPulse) errTot++;
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  int gotDone, gotErr, nReads, nLows, nCyc, nAddrBad;
  task automatic runOp(input bit er, input bit tg, input logic [DW-1:0] ex,
                       input logic [AW-1:0] ad, input int spurAt);
    int r0, l0, a0;
    @(negedge clk);
    baseIdx = rdIdx; expAddr = ad;
    r0 = readTot; l0 = lowTot; a0 = addrBadTot;
    eraseMode = er; toggleMode = tg; expData = ex; tgtAddr = ad;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0; watching = 1'b1;
    nCyc = 1;
    while (!(donePulse || errPulse) && nCyc < 3000) begin
      @(negedge clk);
      nCyc++;
      startPulse = (nCyc == spurAt);
      if (nCyc == spurAt) tgtAddr = ad ^ 1;
    end
    startPulse = 1'b0;
    gotDone = donePulse; gotErr = errPulse;
    @(negedge clk);
    watching = 1'b0;
    nReads = readTot - r0; nLows = lowTot - l0; nAddrBad = addrBadTot - a0;
    chk(!donePulse && !errPulse, "R11 pulse width", donePulse + errPulse, 0);
    chk(nAddrBad == 0, "R2 read address", nAddrBad, 0);
    repeat (4) @(negedge clk);
  endtask

  localparam logic [DW-1:0] E = 16'hA55A; // bit 7 = 0
  localparam logic [AW-1:0] A = 22'h15A3C;

  task automatic t_reset();
    chk(!donePulse, "R1 done", donePulse, 0);
    chk(!errPulse, "R1 err", errPulse, 0);
    chk(!rdReq, "R1 rdReq", rdReq, 0);
  endtask

  task automatic t_prog_poll();  // R3 R6 R7
    nRsp = 4; rsp[0] = ~E; rsp[1] = ~E; rsp[2] = ~E; rsp[3] = E; tail = E;
    runOp(1'b0, 1'b0, E, A, 0);
    chk(gotDone == 1 && gotErr == 0, "R3 program done", gotDone, 1);
    chk(nReads == 5, "R7 program reads", nReads, 5);
    chk(nLows == SETTLE, "R6 settle gap", nLows, SETTLE);
  endtask

  task automatic t_erase_poll(); // R4 R7
    nRsp = 3; rsp[0] = '0; rsp[1] = '0; rsp[2] = '1; tail = '1;
    runOp(1'b1, 1'b0, E, A + 5, 0);
    chk(gotDone == 1, "R4 erase done", gotDone, 1);
    chk(nReads == 4, "R4 erase reads", nReads, 4);
  endtask

  task automatic t_toggle();     // R5: bit 7 of every word already matches
    nRsp = 5; rsp[0] = 16'h0040; rsp[1] = 16'h0000; rsp[2] = 16'h0040;
    rsp[3] = 16'h0000; rsp[4] = 16'h0000; tail = 16'h1234;
    runOp(1'b0, 1'b1, 16'h1234, A + 9, 0);
    chk(gotDone == 1, "R5 toggle done", gotDone, 1);
    chk(nReads == 6, "R5 toggle reads", nReads, 6);
  endtask

  task automatic t_erase_race(); // R8 with erase target
    nRsp = 4; rsp[0] = '0; rsp[1] = 16'h00FF; rsp[2] = 16'h00FF; rsp[3] = '1; tail = '1;
    runOp(1'b1, 1'b0, E, A, 0);
    chk(gotDone == 1 && gotErr == 0, "R8 erase race done", gotDone, 1);
    chk(nReads == 5, "R8 erase race reads", nReads, 5);
  endtask

  task automatic t_prog_race();  // R8
    nRsp = 2; rsp[0] = E; rsp[1] = E ^ 16'h0100; tail = E;
    runOp(1'b0, 1'b0, E, A, 0);
    chk(gotDone == 1 && gotErr == 0, "R8 program race done", gotDone, 1);
    chk(nReads == 4, "R8 program race reads", nReads, 4);
  endtask

  task automatic t_fail(input bit firstBad); // R9
    nRsp = 4; rsp[0] = E; rsp[1] = E ^ 16'h0001;
    rsp[2] = firstBad ? (E ^ 16'h0001) : E;
    rsp[3] = firstBad ? E : (E ^ 16'h0001);
    tail = E;
    runOp(1'b0, 1'b0, E, A, 0);
    chk(gotErr == 1 && gotDone == 0, "R9 confirm failure", gotErr, 1);
    chk(nReads == 4, "R9 failure reads", nReads, 4);
  endtask

  task automatic t_timeout();    // R10
    nRsp = 0; tail = ~E;
    runOp(1'b0, 1'b0, E, A, 0);
    chk(gotErr == 1 && gotDone == 0, "R10 timeout error", gotErr, 1);
    chk(nCyc == TMO + 1, "R10 timeout cycle", nCyc, TMO + 1);
  endtask

  task automatic t_ignore();     // R12
    int d0;
    nRsp = 5; rsp[0] = ~E; rsp[1] = ~E; rsp[2] = ~E; rsp[3] = ~E; rsp[4] = E; tail = E;
    runOp(1'b0, 1'b0, E, A, 4);
    d0 = doneTot;
    repeat (120) @(negedge clk);
    chk(gotDone == 1, "R12 original op done", gotDone, 1);
    chk(nReads == 6, "R12 read count", nReads, 6);
    chk(doneTot == d0 && !rdReq, "R12 no second op", doneTot - d0, 0);
  endtask

  initial begin
    bit wdFail = 1'b0;
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rstN = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_prog_poll();
        t_erase_poll();
        t_toggle();
        t_erase_race();
        t_prog_race();
        t_fail(1'b1);
        t_fail(1'b0);
        t_timeout();
        t_ignore();
      end
      begin
        repeat (150000) @(posedge clk);
        wdFail = 1'b1;
      end
    join_any
    disable fork;
    if (wdFail) chk(1'b0, "watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule